// File: doc/BRIEF.md
# Request-Driven SPI Frame Master

This block is the master end of a point-to-many SPI link on a stack of plug-in modules. Each slave module owns one request line and one active-low select line. The host arms the engine with a start pulse. The engine then waits for a request. When requests arrive it chooses one slave in round-robin order and selects it. It then exchanges one frame of fixed size in both directions and releases the slave. Finally it reports which slave was served and whether the received frame can be trusted.

A frame begins with an eight-byte header. The header holds a 16-bit destination, a 16-bit source, a message tag byte and an opcode byte, then a 16-bit payload count. All 16-bit fields are sent high byte first. The payload follows, then a single checksum byte, and zero bytes fill the rest of the frame. The host loads the outgoing header and payload into a byte-addressed transmit store, and the engine inserts the checksum and the filler itself. Incoming bytes are written into a byte-addressed receive store that the host reads without any timing restriction. The received frame is checked for a plausible payload count and for a correct checksum, and a frame that fails either check is not flagged as valid.

Top module: `spi_frame_master`

## Requirements
- R1: While reset is held and right after it, busy, done, sclk, rx_valid, rx_csum_err and rx_len_err are 0 and every select line is high.
- R2: After a start pulse, busy is 1 but no select line goes low and sclk stays low until at least one request line is high.
- R3: When several requests are pending, the grant goes to the first requester found by scanning upward from the slave after the one served last (slave 0 first after reset), wrapping around.
- R4: During a transfer exactly one select line is low, and it belongs to the granted slave.
- R5: SPI mode 0. The select line goes low at least 2*HALF_DIV clocks before the first rising sclk edge. Every sclk high phase lasts exactly HALF_DIV clocks. Each transfer has exactly 8*FRAME_LEN rising edges. The select line is held at least 2*HALF_DIV clocks after the last falling edge.
- R6: Transmitted bytes go out MSB first. Let L be the transmit-store value {byte 6, byte 7}, limited to CAP = FRAME_LEN-9. Bytes 0 to 7+L come from the transmit store. Byte 8+L is the modulo-256 sum of those bytes. All later bytes are 0x00.
- R7: MISO is sampled on the rising edge, MSB first. Received byte k can be read at rx_addr = k after done.
- R8: If the received count {byte 6, byte 7} is at most CAP and byte 8+count equals the modulo-256 sum of bytes 0 to 7+count, then rx_valid is 1 and both error flags are 0 after done.
- R9: If the count is at most CAP but the checksum byte differs, then rx_csum_err is 1 and rx_valid and rx_len_err are 0 after done.
- R10: If the count exceeds CAP, then rx_len_err is 1 and rx_valid and rx_csum_err are 0 after done.
- R11: done is high for exactly one clock, in the first clock with busy low, and done_slv then holds the index of the served slave.
- R12: A start pulse while busy is ignored: once the current transfer ends the engine stays idle even if requests remain high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-clock pulse that arms one transfer |
| tx_we | input | 1 | Transmit store write enable |
| tx_addr | input | $clog2(FRAME_LEN) | Transmit store byte address |
| tx_wdata | input | 8 | Transmit store write data |
| rx_addr | input | $clog2(FRAME_LEN) | Receive store byte address |
| rx_rdata | output | 8 | Receive store read data (combinational) |
| busy | output | 1 | Engine armed or transferring |
| done | output | 1 | One-clock completion pulse |
| done_slv | output | $clog2(N_SLV) | Index of the slave last served |
| rx_valid | output | 1 | Last received frame passed both checks |
| rx_csum_err | output | 1 | Last received frame failed the checksum |
| rx_len_err | output | 1 | Last received frame had a count beyond capacity |
| slv_req | input | N_SLV | Per-slave service request lines |
| slv_sel_n | output | N_SLV | Per-slave active-low select lines |
| sclk | output | 1 | SPI serial clock, idle low |
| mosi | output | 1 | Master-out serial data |
| miso | input | 1 | Master-in serial data |

## Verification
A corrupted arbiter pointer shows at the select lines and at done_slv as soon as the next grant is made. A wrong byte index or a stale checksum accumulator changes the MOSI bit stream within one byte time, and the checksum byte exposes it by the end of the frame at the latest. Errors in the receive checker are visible only when the frame ends, through rx_valid and the two error flags. A bit-timing or edge-count fault shows as a high phase of the wrong length or a rising-edge total other than 8*FRAME_LEN, and the select lead and hold margins catch sequencer timing slips.

// File: rtl/sfm_pkg.sv
// Shared constants and the sequencer state type of the SPI frame master.
package sfm_pkg;
    localparam int SFM_HDR_BYTES = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAITQ,
        ST_LEAD,
        ST_XFER,
        ST_TAIL
    } sfm_state_e;
endpackage

// File: rtl/sfm_rr_arb.sv
// Round-robin request picker. It scans upward from the slot after the last
// grant and picks the first active request. Assumes that take is asserted
// only in a cycle where any is high.
module sfm_rr_arb #(
    parameter int N  = 4,
    parameter int SW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  req,
    input  logic          take,
    output logic [SW-1:0] gnt,
    output logic          any
);
    logic [SW-1:0] ptr_q;

    // Find the first requester at or after the pointer, wrapping around.
    always_comb begin
        any = 1'b0;
        gnt = ptr_q;
        for (int k = N - 1; k >= 0; k--) begin
            int j;
            j = (int'(ptr_q) + k) % N;
            if (req[j]) begin
                any = 1'b1;
                gnt = SW'(j);
            end
        end
    end

    // Move the pointer past the slot that was granted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (take) begin
            ptr_q <= (gnt == SW'(N - 1)) ? '0 : gnt + 1'b1;
        end
    end
endmodule

// File: rtl/sfm_bit_engine.sv
// Byte serializer for SPI mode 0. A load pulse starts one byte. sclk is low
// for HALF_DIV clocks and then high for HALF_DIV clocks per bit. MISO is
// taken at the rising edge and MOSI moves at the falling edge. done pulses
// for one clock at the last falling edge. Assumes load arrives only while idle.
module sfm_bit_engine #(
    parameter int HALF_DIV = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic [7:0] tx_byte,
    input  logic       miso,
    output logic       sclk,
    output logic       mosi,
    output logic       done,
    output logic [7:0] rx_byte
);
    localparam int HW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [HW-1:0] HALF_LAST = HW'(HALF_DIV - 1);

    logic [7:0]    sh_tx_q;
    logic [7:0]    sh_rx_q;
    logic [HW-1:0] cnt_q;
    logic [2:0]    bit_q;
    logic          act_q;
    logic          sclk_q;
    logic          done_q;

    // Half-period timing, edge generation and both shift registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_tx_q <= '0;
            sh_rx_q <= '0;
            cnt_q   <= '0;
            bit_q   <= '0;
            act_q   <= 1'b0;
            sclk_q  <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (load) begin
                sh_tx_q <= tx_byte;
                cnt_q   <= '0;
                bit_q   <= '0;
                act_q   <= 1'b1;
                sclk_q  <= 1'b0;
            end else if (act_q) begin
                if (cnt_q == HALF_LAST) begin
                    cnt_q <= '0;
                    if (!sclk_q) begin
                        sclk_q  <= 1'b1;
                        sh_rx_q <= {sh_rx_q[6:0], miso};
                    end else begin
                        sclk_q <= 1'b0;
                        if (bit_q == 3'd7) begin
                            act_q  <= 1'b0;
                            done_q <= 1'b1;
                        end else begin
                            bit_q   <= bit_q + 3'd1;
                            sh_tx_q <= {sh_tx_q[6:0], 1'b0};
                        end
                    end
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    assign sclk    = sclk_q;
    assign mosi    = sh_tx_q[7];
    assign done    = done_q;
    assign rx_byte = sh_rx_q;
endmodule

// File: rtl/sfm_rx_check.sv
// Receive-side frame checker. It reads the payload count from bytes 6 and 7,
// sums every byte before the checksum position and compares the byte at that
// position. Assumes bytes arrive in index order after a clear.
module sfm_rx_check #(
    parameter int AW  = 4,
    parameter int CAP = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          vld,
    input  logic [AW-1:0] idx,
    input  logic [7:0]    data,
    output logic          len_bad,
    output logic          sum_bad
);
    import sfm_pkg::*;

    logic [15:0] len_q;
    logic [7:0]  sum_q;
    logic        match_q;
    logic [16:0] idx17;
    logic [16:0] end17;

    assign idx17   = 17'(idx);
    assign end17   = 17'(SFM_HDR_BYTES) + {1'b0, len_q};
    assign len_bad = (len_q > 16'(CAP));
    assign sum_bad = !len_bad && !match_q;

    // Capture the count, accumulate the sum and latch the compare result.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            len_q   <= '0;
            sum_q   <= '0;
            match_q <= 1'b0;
        end else if (vld) begin
            if (idx17 == 17'd6) len_q[15:8] <= data;
            if (idx17 == 17'd7) len_q[7:0]  <= data;
            if (idx17 < 17'(SFM_HDR_BYTES) || idx17 < end17) begin
                sum_q <= sum_q + data;
            end
            if (!len_bad && idx17 == end17) begin
                match_q <= (data == sum_q);
            end
        end
    end
endmodule

// File: rtl/spi_frame_master.sv
// SPI frame master. A start pulse arms one transfer. The engine waits for a
// slave request, grants in round-robin order, selects the slave, exchanges
// FRAME_LEN bytes with the checksum and filler inserted, and reports the
// result. Assumes the transmit store is not written while busy.
module spi_frame_master #(
    parameter int N_SLV     = 4,
    parameter int FRAME_LEN = 16,
    parameter int HALF_DIV  = 2,
    parameter int AW        = $clog2(FRAME_LEN),
    parameter int SW        = (N_SLV > 1) ? $clog2(N_SLV) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             tx_we,
    input  logic [AW-1:0]    tx_addr,
    input  logic [7:0]       tx_wdata,
    input  logic [AW-1:0]    rx_addr,
    output logic [7:0]       rx_rdata,
    output logic             busy,
    output logic             done,
    output logic [SW-1:0]    done_slv,
    output logic             rx_valid,
    output logic             rx_csum_err,
    output logic             rx_len_err,
    input  logic [N_SLV-1:0] slv_req,
    output logic [N_SLV-1:0] slv_sel_n,
    output logic             sclk,
    output logic             mosi,
    input  logic             miso
);
    import sfm_pkg::*;

    localparam int CAP = FRAME_LEN - SFM_HDR_BYTES - 1;
    localparam int CW  = $clog2(2 * HALF_DIV) > 0 ? $clog2(2 * HALF_DIV) : 1;
    localparam logic [CW-1:0] GAP_LAST = CW'(2 * HALF_DIV - 1);
    localparam logic [AW-1:0] LAST_IDX = AW'(FRAME_LEN - 1);

    sfm_state_e        state_q;
    logic [CW-1:0]     cnt_q;
    logic [AW-1:0]     idx_q;
    logic [7:0]        sum_q;
    logic [SW-1:0]     cur_q;
    logic [N_SLV-1:0]  sel_n_q;
    logic              done_q;
    logic              valid_q, cerr_q, lerr_q;

    logic [7:0]        tx_mem [FRAME_LEN];
    logic [7:0]        rx_mem [FRAME_LEN];

    logic [SW-1:0]     arb_gnt;
    logic              arb_any;
    logic              arb_take;
    logic              be_load, be_done;
    logic [7:0]        be_rx;
    logic [7:0]        tx_byte;
    logic [AW-1:0]     nidx;
    logic [15:0]       tx_len, eff_len, csum_pos, nidx16;
    logic              rx_vld, rx_clr, len_bad, sum_bad;

    // Host write port of the transmit store.
    always_ff @(posedge clk) begin
        if (tx_we) tx_mem[tx_addr] <= tx_wdata;
    end

    // Work out where the checksum goes and pick the next outgoing byte.
    always_comb begin
        tx_len   = {tx_mem[6], tx_mem[7]};
        eff_len  = (tx_len > 16'(CAP)) ? 16'(CAP) : tx_len;
        csum_pos = 16'(SFM_HDR_BYTES) + eff_len;
        nidx     = (state_q == ST_LEAD) ? '0 : idx_q + 1'b1;
        nidx16   = 16'(nidx);
        if (nidx16 < csum_pos)       tx_byte = tx_mem[nidx];
        else if (nidx16 == csum_pos) tx_byte = sum_q;
        else                         tx_byte = 8'h00;
    end

    assign be_load  = (state_q == ST_LEAD && cnt_q == GAP_LAST) ||
                      (state_q == ST_XFER && be_done && idx_q != LAST_IDX);
    assign arb_take = (state_q == ST_WAITQ) && arb_any;
    assign rx_vld   = (state_q == ST_XFER) && be_done;
    assign rx_clr   = (state_q == ST_WAITQ);

    // Transfer sequencer: arm, grant, lead gap, bytes, tail gap, report.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            idx_q   <= '0;
            sum_q   <= '0;
            cur_q   <= '0;
            sel_n_q <= '1;
            done_q  <= 1'b0;
            valid_q <= 1'b0;
            cerr_q  <= 1'b0;
            lerr_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        state_q <= ST_WAITQ;
                        valid_q <= 1'b0;
                        cerr_q  <= 1'b0;
                        lerr_q  <= 1'b0;
                    end
                end
                ST_WAITQ: begin
                    if (arb_any) begin
                        cur_q   <= arb_gnt;
                        sel_n_q <= ~(N_SLV'(1) << arb_gnt);
                        cnt_q   <= '0;
                        sum_q   <= '0;
                        state_q <= ST_LEAD;
                    end
                end
                ST_LEAD: begin
                    if (cnt_q == GAP_LAST) begin
                        cnt_q   <= '0;
                        idx_q   <= '0;
                        state_q <= ST_XFER;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                ST_XFER: begin
                    if (be_done) begin
                        if (idx_q == LAST_IDX) begin
                            cnt_q   <= '0;
                            state_q <= ST_TAIL;
                        end else begin
                            idx_q <= idx_q + 1'b1;
                        end
                    end
                end
                ST_TAIL: begin
                    if (cnt_q == GAP_LAST) begin
                        sel_n_q <= '1;
                        done_q  <= 1'b1;
                        valid_q <= !len_bad && !sum_bad;
                        cerr_q  <= sum_bad;
                        lerr_q  <= len_bad;
                        state_q <= ST_IDLE;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
            if (be_load && nidx16 < csum_pos) begin
                sum_q <= sum_q + tx_byte;
            end
        end
    end

    // Store each received byte at its frame position.
    always_ff @(posedge clk) begin
        if (rx_vld) rx_mem[idx_q] <= be_rx;
    end

    sfm_rr_arb #(.N(N_SLV), .SW(SW)) arb_i (
        .clk  (clk),
        .rst_n(rst_n),
        .req  (slv_req),
        .take (arb_take),
        .gnt  (arb_gnt),
        .any  (arb_any)
    );

    sfm_bit_engine #(.HALF_DIV(HALF_DIV)) bit_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (be_load),
        .tx_byte(tx_byte),
        .miso   (miso),
        .sclk   (sclk),
        .mosi   (mosi),
        .done   (be_done),
        .rx_byte(be_rx)
    );

    sfm_rx_check #(.AW(AW), .CAP(CAP)) chk_rx_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (rx_clr),
        .vld    (rx_vld),
        .idx    (idx_q),
        .data   (be_rx),
        .len_bad(len_bad),
        .sum_bad(sum_bad)
    );

    assign rx_rdata    = rx_mem[rx_addr];
    assign busy        = (state_q != ST_IDLE);
    assign done        = done_q;
    assign done_slv    = cur_q;
    assign rx_valid    = valid_q;
    assign rx_csum_err = cerr_q;
    assign rx_len_err  = lerr_q;
    assign slv_sel_n   = sel_n_q;
endmodule

// File: rtl/sfm_checker.sv
// Port-level protocol checker for spi_frame_master, attached with bind.
module sfm_checker #(
    parameter int N_SLV = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             busy,
    input logic             done,
    input logic             sclk,
    input logic             rx_valid,
    input logic             rx_csum_err,
    input logic             rx_len_err,
    input logic [N_SLV-1:0] slv_req,
    input logic [N_SLV-1:0] slv_sel_n
);
    a_r4_single_select: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~slv_sel_n));

    a_r2_idle_no_select: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> &slv_sel_n);

    a_r2_select_needs_request: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(&slv_sel_n) && !(&slv_sel_n)) |-> $past(|slv_req));

    a_r5_sclk_low_unselected: assert property (@(posedge clk) disable iff (!rst_n)
        &slv_sel_n |-> !sclk);

    a_r11_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r11_done_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    a_r12_busy_ends_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    a_r8_valid_clean: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> (!rx_csum_err && !rx_len_err));

    a_r10_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(rx_csum_err && rx_len_err));
endmodule

bind spi_frame_master sfm_checker #(.N_SLV(N_SLV)) sfm_chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy       (busy),
    .done       (done),
    .sclk       (sclk),
    .rx_valid   (rx_valid),
    .rx_csum_err(rx_csum_err),
    .rx_len_err (rx_len_err),
    .slv_req    (slv_req),
    .slv_sel_n  (slv_sel_n)
);

// File: tb/spi_frame_master_tb_top.sv
`timescale 1ns/1ps
// Directed bench for spi_frame_master: one task per scenario, bit-level slave model in the transfer task.
module spi_frame_master_tb_top;
    localparam int NS  = 4;
    localparam int FL  = 16;
    localparam int H   = 2;
    localparam int AW  = 4;
    localparam int SW  = 2;
    localparam int CAP = FL - 9;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          tx_we = 1'b0;
    logic [AW-1:0] tx_addr = '0;
    logic [7:0]    tx_wdata = '0;
    logic [AW-1:0] rx_addr = '0;
    logic [7:0]    rx_rdata;
    logic          busy, done, rx_valid, rx_csum_err, rx_len_err;
    logic [SW-1:0] done_slv;
    logic [NS-1:0] slv_req = '0;
    logic [NS-1:0] slv_sel_n;
    logic          sclk, mosi;
    logic          miso = 1'b0;

    int n_chk = 0;
    int n_err = 0;
    int cyc   = 0;
    logic [7:0] tx_img [FL];
    logic [7:0] rsp    [FL];

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    spi_frame_master #(.N_SLV(NS), .FRAME_LEN(FL), .HALF_DIV(H)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start),
        .tx_we(tx_we), .tx_addr(tx_addr), .tx_wdata(tx_wdata),
        .rx_addr(rx_addr), .rx_rdata(rx_rdata),
        .busy(busy), .done(done), .done_slv(done_slv),
        .rx_valid(rx_valid), .rx_csum_err(rx_csum_err), .rx_len_err(rx_len_err),
        .slv_req(slv_req), .slv_sel_n(slv_sel_n),
        .sclk(sclk), .mosi(mosi), .miso(miso)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
        $finish;
    endtask

    // Watchdog: a hung run is counted as a failure and still reports.
    initial begin
        wait (cyc >= 150000);
        chk(1'b0, "watchdog", cyc, 150000);
        summary();
    end

    task automatic write_tx();
        for (int i = 0; i < FL; i++) begin
            @(negedge clk);
            tx_we = 1'b1; tx_addr = AW'(i); tx_wdata = tx_img[i];
        end
        @(negedge clk);
        tx_we = 1'b0;
    endtask

    task automatic make_tx(input int len, input logic [7:0] seed);
        for (int i = 0; i < FL; i++) tx_img[i] = seed + 8'(i * 29);
        tx_img[6] = 8'(len >> 8);
        tx_img[7] = 8'(len);
    endtask

    task automatic make_rsp(input int len, input bit corrupt, input logic [7:0] seed);
        logic [7:0] s;
        s = 8'h00;
        for (int i = 0; i < FL; i++) rsp[i] = seed ^ 8'(i * 53 + 7);
        rsp[6] = 8'(len >> 8);
        rsp[7] = 8'(len);
        if (len <= CAP) begin
            for (int i = 0; i < 8 + len; i++) s = s + rsp[i];
            rsp[8 + len] = corrupt ? ~s : s;
            for (int i = 9 + len; i < FL; i++) rsp[i] = 8'h00;
        end
    endtask

    // Drive requests, play the slave, and check timing, both frames and the result flags.
    task automatic run_xfer(input logic [NS-1:0] req, input bit do_start, input bit mid_start,
                            input int exp_slv, input bit exp_v, input bit exp_c, input bit exp_l);
        logic [7:0]    exp_tx [FL];
        logic [7:0]    cap    [FL];
        logic [7:0]    s;
        logic [NS-1:0] seen;
        int  len, rises, hirun, bad_hi, lead, tail, mid_st, first_bad;
        bit  prev, got_done;
        len = {tx_img[6], tx_img[7]};
        if (len > CAP) len = CAP;
        s = 8'h00;
        for (int i = 0; i < FL; i++) begin
            if (i < 8 + len) begin exp_tx[i] = tx_img[i]; s = s + tx_img[i]; end
            else if (i == 8 + len) exp_tx[i] = s;
            else exp_tx[i] = 8'h00;
            cap[i] = 8'h00;
        end
        seen = '0; rises = 0; hirun = 0; bad_hi = 0; lead = 0; tail = 0; mid_st = 0;
        prev = 1'b0; got_done = 1'b0;
        @(negedge clk);
        miso = rsp[0][7];
        slv_req = req;
        if (do_start) begin start = 1'b1; @(negedge clk); start = 1'b0; end
        for (int t = 0; t < 5000 && !got_done; t++) begin
            @(negedge clk);
            if (mid_st == 1) begin start = 1'b0; mid_st = 2; end
            seen = seen | ~slv_sel_n;
            if (sclk && !prev) begin
                if (rises < 8 * FL) cap[rises / 8][7 - rises % 8] = mosi;
                rises++;
                hirun = 1;
            end else if (sclk) begin
                hirun++;
            end
            if (!sclk && prev) begin
                if (hirun != H) bad_hi++;
                if (rises < 8 * FL) miso = rsp[rises / 8][7 - rises % 8];
            end
            if (!(&slv_sel_n) && !sclk && rises == 0) lead++;
            if (!(&slv_sel_n) && !sclk && rises == 8 * FL) tail++;
            if (mid_start && mid_st == 0 && rises == 64) begin start = 1'b1; mid_st = 1; end
            prev = sclk;
            got_done = done;
        end
        chk(got_done, "R11 done seen", 32'(got_done), 1);
        chk(busy == 1'b0, "R11 busy low with done", 32'(busy), 0);
        chk(done_slv == SW'(exp_slv), "R3/R11 served slave", 32'(done_slv), 32'(exp_slv));
        chk(seen == NS'(1 << exp_slv), "R4 select line used", 32'(seen), 32'(1 << exp_slv));
        chk(rises == 8 * FL, "R5 rising edge count", rises, 8 * FL);
        chk(bad_hi == 0, "R5 high phase length", bad_hi, 0);
        chk(lead >= 2 * H, "R5 select lead", lead, 2 * H);
        chk(tail >= 2 * H, "R5 select hold", tail, 2 * H);
        first_bad = -1;
        for (int i = FL - 1; i >= 0; i--) if (cap[i] != exp_tx[i]) first_bad = i;
        chk(first_bad < 0, "R6 transmitted frame",
            first_bad < 0 ? 32'(0) : 32'(cap[first_bad]),
            first_bad < 0 ? 32'(0) : 32'(exp_tx[first_bad]));
        chk(rx_valid == exp_v, "R8 rx_valid", 32'(rx_valid), 32'(exp_v));
        chk(rx_csum_err == exp_c, "R9 rx_csum_err", 32'(rx_csum_err), 32'(exp_c));
        chk(rx_len_err == exp_l, "R10 rx_len_err", 32'(rx_len_err), 32'(exp_l));
        @(negedge clk);
        chk(done == 1'b0, "R11 done one cycle", 32'(done), 0);
        for (int i = 0; i < FL; i++) begin
            rx_addr = AW'(i);
            #1;
            chk(rx_rdata == rsp[i], "R7 receive store", 32'(rx_rdata), 32'(rsp[i]));
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(busy == 0 && done == 0 && sclk == 0, "R1 control idle in reset",
            {busy, done, sclk}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(slv_sel_n == '1, "R1 selects high", 32'(slv_sel_n), 32'hF);
        chk(rx_valid == 0 && rx_csum_err == 0 && rx_len_err == 0, "R1 flags clear",
            {rx_valid, rx_csum_err, rx_len_err}, 0);
    endtask

    // R2: armed without a request, then served once slave 1 asks.
    task automatic t_wait_for_request();
        make_tx(3, 8'h11); write_tx();
        make_rsp(2, 1'b0, 8'hA5);
        @(negedge clk); start = 1'b1; @(negedge clk); start = 1'b0;
        repeat (40) @(negedge clk);
        chk(busy == 1'b1, "R2 busy while waiting", 32'(busy), 1);
        chk(slv_sel_n == '1 && sclk == 1'b0, "R2 no select without request",
            {slv_sel_n, sclk}, 32'h1E);
        run_xfer(4'b0010, 1'b0, 1'b0, 1, 1'b1, 1'b0, 1'b0);
        slv_req = '0;
    endtask

    // R6 full capacity frame and R9 checksum error; pointer sits at 2, only slave 0 asks.
    task automatic t_full_and_bad_sum();
        make_tx(CAP, 8'h3C); write_tx();
        make_rsp(CAP, 1'b1, 8'h5A);
        run_xfer(4'b0001, 1'b1, 1'b0, 0, 1'b0, 1'b1, 1'b0);
        slv_req = '0;
    endtask

    // R6 empty payload and length clamp; R10 count beyond capacity (low and high byte).
    task automatic t_length_cases();
        make_tx(0, 8'hC3); write_tx();
        make_rsp(16, 1'b0, 8'h77);
        run_xfer(4'b1000, 1'b1, 1'b0, 3, 1'b0, 1'b0, 1'b1);
        slv_req = '0;
        make_tx(9, 8'h81); write_tx();
        make_rsp(256, 1'b0, 8'h19);
        run_xfer(4'b1000, 1'b1, 1'b0, 3, 1'b0, 1'b0, 1'b1);
        slv_req = '0;
    endtask

    // R3 rotation with held requests, R12 start during a transfer has no effect.
    task automatic t_round_robin();
        make_tx(5, 8'h42); write_tx();
        make_rsp(4, 1'b0, 8'h0F);
        run_xfer(4'b1101, 1'b1, 1'b1, 0, 1'b1, 1'b0, 1'b0);
        repeat (30) @(negedge clk);
        chk(busy == 1'b0, "R12 start while busy ignored", 32'(busy), 0);
        chk(slv_sel_n == '1, "R12 no select after ignored start", 32'(slv_sel_n), 32'hF);
        make_rsp(1, 1'b0, 8'hE1);
        run_xfer(4'b1101, 1'b1, 1'b0, 2, 1'b1, 1'b0, 1'b0);
        make_rsp(7, 1'b0, 8'h2B);
        run_xfer(4'b1101, 1'b1, 1'b0, 3, 1'b1, 1'b0, 1'b0);
        make_rsp(0, 1'b0, 8'h99);
        run_xfer(4'b1101, 1'b1, 1'b0, 0, 1'b1, 1'b0, 1'b0);
        slv_req = '0;
    endtask

    initial begin
        t_reset();
        t_wait_for_request();
        t_full_and_bad_sum();
        t_length_cases();
        t_round_robin();
        repeat (5) @(negedge clk);
        summary();
    end
endmodule